// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Dead Time and Switch Protection

This block produces the four gate commands of one full H-bridge. The bridge has two legs. Each leg has a high-side and a low-side switch. A 2-bit request selects one of four bridge states: off, forward, reverse or slow decay. The block moves the gates to that state and inserts a programmable dead time at every changeover, so that the two switches of a leg never conduct together. A global enable forces every gate off while it is low, which leaves the motor outputs floating.

Two per-switch inputs come from the analog side.

- **Overvoltage flag.** When this flag is raised on a conducting switch, the switch is opened and stays locked open. A sticky status bit reports the lock. Dropping the enable for a cycle clears both the lock and the status bit.
- **Reverse-current flag.** When this flag is raised on an open switch, the block closes that switch as an active diode. This happens only when the request gives that switch's partner no command and the partner's own dead time has run out.

Top module: `hbridge_gate_seq`

## Requirements
- R1: Reset clears all gates and fault bits. While `enable` is sampled low at a clock edge, every gate and every fault bit is 0 after that edge.
- R2: `gate[0]` (high A) and `gate[1]` (low A) are never both 1. `gate[2]` (high B) and `gate[3]` (low B) are never both 1.
- R3: Request encoding: 00 off (gate 0000), 01 forward (gate 1001), 10 reverse (gate 0110), 11 slow decay (gate 1010). From an idle leg whose dead time has expired, the gates reach the requested pattern one clock edge after the request is sampled.
- R4: When a leg switches from one conducting switch to the other, both gates of that leg read 0 for exactly D cycles, where D is `dead_cfg`. A switch is never turned on while its leg's dead time is still running.
- R5: A `dead_cfg` value of 0 gives the same result as 1: one cycle with both gates off.
- R6: If `ovp_flag[i]` is 1 at an edge while `gate[i]` is 1 and `enable` is 1, then after that edge `gate[i]` is 0 and `fault_stat[i]` is 1.
- R7: A switch whose fault bit is set stays off, even when the request asks for it. Its fault bit stays set while `enable` remains 1. Clearing `enable` for one cycle and setting it again allows the switch to turn on normally.
- R8: If `rev_flag[i]` is 1 for an open switch whose partner has no command in the current request, that switch turns on, subject to R4. It turns off one edge after the flag drops. If the partner is commanded, the flag has no effect.
- R9: If both reverse-current flags of a leg are raised and neither switch of that leg is commanded, the high side is the one turned on.
- R10: `ovp_flag` raised on a switch that is off sets no fault bit and does not stop that switch from turning on later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Global bridge enable. Low forces all gates off and clears the locks |
| dead_cfg | input | DT_W (4) | Dead time in cycles. 0 is treated as 1 |
| state_req | input | 2 | Requested bridge state |
| ovp_flag | input | 4 | Per-switch overvoltage flag, indexed [LB, HB, LA, HA] |
| rev_flag | input | 4 | Per-switch reverse-current flag, indexed [LB, HB, LA, HA] |
| gate | output | 4 | Gate commands [LB, HB, LA, HA] |
| fault_stat | output | 4 | Sticky per-switch overvoltage lock |

## Verification
Every gate and fault bit is a register. Each response to a sampled input therefore appears after a fixed number of edges:

- a new request on an idle leg, an overvoltage trip, a disable and the fall of a reverse-current flag all take effect after one edge;
- the opposite switch of a leg comes on after D + 1 edges.

The bench drives inputs just after a falling edge and samples just after the next falling edge. Each expected value is therefore read at a fixed edge count. The dead-time sweep covers every `dead_cfg` value. For each one it counts the consecutive samples with both gates off until the opposite switch turns on, and compares the count with the arithmetic value max(cfg, 1).

// File: rtl/hbg_pkg.sv
package hbg_pkg;

  // Switch slots inside the 4-bit gate vector
  localparam int SW_HA = 0;
  localparam int SW_LA = 1;
  localparam int SW_HB = 2;
  localparam int SW_LB = 3;
  localparam int NUM_SW  = 4;
  localparam int NUM_LEG = NUM_SW / 2;

  typedef enum logic [1:0] {
    BR_OFF   = 2'b00,
    BR_FWD   = 2'b01,
    BR_REV   = 2'b10,
    BR_DECAY = 2'b11
  } bridge_req_e;

  // Requested gate pattern for a bridge state
  function automatic logic [NUM_SW-1:0] bridge_cmd(input logic [1:0] req);
    logic [NUM_SW-1:0] c;
    c = '0;
    case (bridge_req_e'(req))
      BR_FWD:   begin c[SW_HA] = 1'b1; c[SW_LB] = 1'b1; end
      BR_REV:   begin c[SW_HB] = 1'b1; c[SW_LA] = 1'b1; end
      BR_DECAY: begin c[SW_LA] = 1'b1; c[SW_LB] = 1'b1; end
      default:  c = '0;
    endcase
    return c;
  endfunction

  // Timer reload value: a turn-off edge counts as the first dead cycle,
  // so the counter holds D-1; a zero setting behaves like one
  function automatic logic [15:0] dead_load(input logic [15:0] cfg);
    return (cfg == 16'd0) ? 16'd0 : cfg - 16'd1;
  endfunction

endpackage

// File: rtl/hbg_cmd_decode.sv
module hbg_cmd_decode
  import hbg_pkg::*;
(
  input  logic [1:0]        state_req,
  input  logic [NUM_SW-1:0] rev_flag,
  output logic [NUM_SW-1:0] want
);

  logic [NUM_SW-1:0] cmd;

  assign cmd = bridge_cmd(state_req);

  generate
    for (genvar l = 0; l < NUM_LEG; l++) begin : g_leg
      logic hi_w, lo_w;
      // Command first; active diode only when the partner is not commanded
      assign hi_w = cmd[2*l]   | (rev_flag[2*l]   & ~cmd[2*l+1]);
      assign lo_w = (cmd[2*l+1] | (rev_flag[2*l+1] & ~cmd[2*l])) & ~hi_w;
      assign want[2*l]   = hi_w;
      assign want[2*l+1] = lo_w;
    end
  endgenerate

endmodule

// File: rtl/hbg_dead_timer.sv
module hbg_dead_timer
  import hbg_pkg::*;
#(
  parameter int DT_W = 4
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DT_W-1:0] dead_cfg,
  input  logic            start,
  output logic            busy
);

  logic [DT_W-1:0] cnt_q;
  logic [DT_W-1:0] load_val;

  assign load_val = DT_W'(dead_load(16'(dead_cfg)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (start)        cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/hbg_leg.sv
module hbg_leg
  import hbg_pkg::*;
#(
  parameter int DT_W = 4
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic [DT_W-1:0] dead_cfg,
  input  logic [1:0]      want,     // [1]=low side, [0]=high side
  input  logic [1:0]      ovp,
  output logic [1:0]      gate_q,
  output logic [1:0]      lock_q,
  output logic [1:0]      trip,
  output logic            dead_busy
);

  logic [1:0] g_q, lk_q, nxt, lk_nxt;
  logic       off_edge;

  generate
    for (genvar s = 0; s < 2; s++) begin : g_sw
      logic keep, start_on;
      assign trip[s]   = enable & g_q[s] & ovp[s];
      assign keep      = g_q[s] & want[s] & ~ovp[s];
      assign start_on  = ~g_q[s] & want[s] & ~lk_q[s] & ~g_q[1-s] & ~dead_busy;
      assign nxt[s]    = enable & (keep | start_on);
      assign lk_nxt[s] = enable & (lk_q[s] | trip[s]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g_q  <= '0;
      lk_q <= '0;
    end else begin
      g_q  <= nxt;
      lk_q <= lk_nxt;
    end
  end

  assign off_edge = |(g_q & ~nxt);

  hbg_dead_timer #(.DT_W(DT_W)) u_dt (
    .clk      (clk),
    .rst_n    (rst_n),
    .dead_cfg (dead_cfg),
    .start    (off_edge),
    .busy     (dead_busy)
  );

  assign gate_q = g_q;
  assign lock_q = lk_q;

endmodule

// File: rtl/hbridge_gate_seq.sv
module hbridge_gate_seq
  import hbg_pkg::*;
#(
  parameter int DT_W = 4
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic [DT_W-1:0] dead_cfg,
  input  logic [1:0]      state_req,
  input  logic [3:0]      ovp_flag,
  input  logic [3:0]      rev_flag,
  output logic [3:0]      gate,
  output logic [3:0]      fault_stat
);

  logic [NUM_SW-1:0]  want;
  logic [NUM_SW-1:0]  ovp_trip;
  logic [NUM_LEG-1:0] dead_busy;

  hbg_cmd_decode u_dec (
    .state_req (state_req),
    .rev_flag  (rev_flag),
    .want      (want)
  );

  generate
    for (genvar l = 0; l < NUM_LEG; l++) begin : g_leg
      hbg_leg #(.DT_W(DT_W)) u_leg (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .dead_cfg  (dead_cfg),
        .want      (want[2*l+1:2*l]),
        .ovp       (ovp_flag[2*l+1:2*l]),
        .gate_q    (gate[2*l+1:2*l]),
        .lock_q    (fault_stat[2*l+1:2*l]),
        .trip      (ovp_trip[2*l+1:2*l]),
        .dead_busy (dead_busy[l])
      );
    end
  endgenerate

endmodule

// File: rtl/hbg_checker.sv
module hbg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic [3:0] gate,
  input logic [3:0] fault_stat,
  input logic [3:0] ovp_trip,
  input logic [1:0] dead_busy
);

  a_r2_no_shoot_through: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate[0] && gate[1]) && !(gate[2] && gate[3]));

  a_r1_disable_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (gate == 4'b0000) && (fault_stat == 4'b0000));

  a_r6_trip_opens_switch: assert property (@(posedge clk) disable iff (!rst_n)
    (ovp_trip != 4'b0000) |=> ((gate & $past(ovp_trip)) == 4'b0000)
                           && ((fault_stat & $past(ovp_trip)) == $past(ovp_trip)));

  a_r7_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> ((fault_stat & $past(fault_stat)) == $past(fault_stat)));

  a_r7_locked_stays_off: assert property (@(posedge clk) disable iff (!rst_n)
    (gate & fault_stat) == 4'b0000);

  a_r4_leg_a_waits: assert property (@(posedge clk) disable iff (!rst_n)
    dead_busy[0] |=> !($rose(gate[0]) || $rose(gate[1])));

  a_r4_leg_b_waits: assert property (@(posedge clk) disable iff (!rst_n)
    dead_busy[1] |=> !($rose(gate[2]) || $rose(gate[3])));

endmodule

bind hbridge_gate_seq hbg_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .gate       (gate),
  .fault_stat (fault_stat),
  .ovp_trip   (ovp_trip),
  .dead_busy  (dead_busy)
);

// File: tb/test_hbridge_gate_seq.sv
`timescale 1ns/1ps
module test_hbridge_gate_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [3:0] dead_cfg = 4'd1;
  logic [1:0] state_req = 2'b00;
  logic [3:0] ovp_flag = 4'b0000;
  logic [3:0] rev_flag = 4'b0000;
  logic [3:0] gate;
  logic [3:0] fault_stat;

  int n_tests = 0;
  int n_fail  = 0;
  int shoot_seen = 0;

  always #2.5 clk = ~clk;

  hbridge_gate_seq i_hbridge_gate_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .dead_cfg(dead_cfg),
    .state_req(state_req), .ovp_flag(ovp_flag), .rev_flag(rev_flag),
    .gate(gate), .fault_stat(fault_stat)
  );

  // Bench view of the request encoding, bits [LB,HB,LA,HA]
  function automatic logic [3:0] exp_pattern(input logic [1:0] r);
    logic [3:0] p;
    p = (r == 2'd1) ? 4'b1001 : (r == 2'd2) ? 4'b0110 : (r == 2'd3) ? 4'b1010 : 4'b0000;
    return p;
  endfunction

  function automatic int exp_dead(input int cfg);
    return (cfg < 1) ? 1 : cfg;
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic chk_int(input int act, input int exp, input string tag);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Shoot-through monitor, sampled away from the active edge
  always @(negedge clk)
    if (rst_n && ((gate[0] && gate[1]) || (gate[2] && gate[3]))) shoot_seen++;

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int zeros;
    step(3);
    chk(gate, 4'b0000, "R1 reset gates");
    chk(fault_stat, 4'b0000, "R1 reset faults");
    rst_n = 1'b1;
    step(2);

    // R3: first turn-on from idle, one edge
    enable = 1'b1;
    state_req = 2'b01;
    step(1);
    chk(gate, 4'b1001, "R3 forward latency one edge");

    // R4/R5: dead-time sweep over every setting
    for (int d = 0; d < 16; d++) begin
      dead_cfg = 4'(d);
      state_req = 2'b01;
      step(20);
      state_req = 2'b10;
      zeros = 0;
      step(1);
      while (gate == 4'b0000 && zeros < 40) begin
        zeros++;
        step(1);
      end
      chk_int(zeros, exp_dead(d), (d == 0) ? "R5 zero setting gap" : "R4 changeover gap");
      chk(gate, 4'b0110, "R4 reverse after gap");
    end

    // R3: all request transitions
    dead_cfg = 4'd2;
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        state_req = 2'(a);
        step(8);
        state_req = 2'(b);
        step(8);
        chk(gate, exp_pattern(2'(b)), "R3 transition pattern");
      end
    end

    // R1: disable forces off regardless of request
    state_req = 2'b01;
    step(8);
    enable = 1'b0;
    step(1);
    chk(gate, 4'b0000, "R1 disable off");
    state_req = 2'b11;
    step(4);
    chk(gate, 4'b0000, "R1 stays off while disabled");
    enable = 1'b1;
    state_req = 2'b01;
    step(8);
    chk(gate, 4'b1001, "R1 re-enable follows");

    // R6/R7: overvoltage on high A
    ovp_flag = 4'b0001;
    step(1);
    ovp_flag = 4'b0000;
    chk(gate, 4'b1000, "R6 tripped switch off");
    chk(fault_stat, 4'b0001, "R6 fault bit set");
    step(10);
    chk(gate, 4'b1000, "R7 locked switch stays off");
    chk(fault_stat, 4'b0001, "R7 fault sticky");
    enable = 1'b0;
    step(1);
    chk(fault_stat, 4'b0000, "R7 disable clears fault");
    enable = 1'b1;
    step(10);
    chk(gate, 4'b1001, "R7 switch usable after re-enable");

    // R10: overvoltage on open switches is ignored
    state_req = 2'b00;
    step(8);
    ovp_flag = 4'b1111;
    step(1);
    ovp_flag = 4'b0000;
    chk(fault_stat, 4'b0000, "R10 no fault when off");
    state_req = 2'b01;
    step(1);
    chk(gate, 4'b1001, "R10 switch turns on normally");

    // R8/R9: active diode
    state_req = 2'b00;
    step(8);
    rev_flag = 4'b0010;
    step(1);
    chk(gate, 4'b0010, "R8 diode on low A");
    rev_flag = 4'b0000;
    step(1);
    chk(gate, 4'b0000, "R8 diode off when flag drops");
    rev_flag = 4'b0001;
    step(1);
    chk(gate, 4'b0000, "R4 diode waits out dead time");
    step(1);
    chk(gate, 4'b0001, "R8 diode on high A after dead time");
    rev_flag = 4'b0000;
    step(8);
    rev_flag = 4'b0011;
    step(1);
    chk(gate, 4'b0001, "R9 high side wins");
    rev_flag = 4'b0000;
    state_req = 2'b01;
    step(8);
    rev_flag = 4'b0010;
    step(6);
    chk(gate, 4'b1001, "R8 commanded partner blocks diode");
    rev_flag = 4'b0000;
    step(2);

    chk_int(shoot_seen, 0, "R2 no shoot-through observed");
    finish_run();
  end

endmodule